// File: doc/BRIEF.md
# Load-Use Hazard Bubble Inserter

This block sits beside the decode stage of a five-stage in-order pipeline. Each cycle it checks whether the instruction being decoded reads a register that a load, one stage further down the pipe, has not yet produced. When that happens it freezes fetch and decode for exactly one cycle. It does this by withholding the load enables of the program counter and the instruction register. In the same cycle it sends an all-zero control word down the pipe instead of the decoded one. The zero word is a bubble: it reads no memory, writes no register and takes no branch. In the following cycle the same instruction decodes again, and the forwarding network covers the dependency.

The source operands compared are the decoded instruction's first source field and its second source field. The second field counts only when the instruction actually reads it. The block works this out from two bits of the decoded control word: the bit that selects an immediate as the second ALU operand, and the bit that marks a memory write (a store reads its data register through the second field). The destination of the load ahead is ignored when it names register 0, since that register is never a true dependency.

A two-state machine carries the one-cycle rule. In FLOW the block passes instructions and watches for a collision. A collision moves it to BUBBLE, which it leaves unconditionally on the next clock edge. In BUBBLE no stall is raised, because the stage ahead is holding the bubble just injected. Transitions: FLOW to FLOW when there is no collision, FLOW to BUBBLE on a collision, BUBBLE to FLOW always.

Top module: `load_use_stall`

## Requirements
- R1: When the stage-ahead data-read flag is 0, both load enables are 1 and the forwarded control word equals the decoded control word bit for bit.
- R2: In FLOW, when the stage-ahead data-read flag is 1, its destination is nonzero and equals the first source field, both load enables are 0 and the forwarded control word is all zeros in that same cycle.
- R3: In FLOW, when the stage-ahead data-read flag is 1, its destination is nonzero and equals the second source field, and the second source field is read, the block stalls as in R2.
- R4: The second source field counts as read when control bit 4 (immediate operand select) is 0 or control bit 1 (memory write) is 1. Otherwise a match on that field alone raises no stall: the enables stay 1 and the control word passes unchanged.
- R5: A stage-ahead destination of register 0 never causes a stall, whatever the source fields hold.
- R6: Every stall lasts exactly one cycle. In the cycle after a stall (state BUBBLE) the enables are 1 and the decoded control word passes unchanged, even if the stage-ahead inputs still show a colliding load.
- R7: The program counter and instruction register load enables always have the same value.
- R8: After reset the block is in FLOW: with no load ahead, both enables are 1 and the control word passes through.
- R9: A load ahead whose nonzero destination matches neither counted source field raises no stall. This covers a back-to-back load that does not depend on the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | 5 | First source register field of the decoded instruction |
| id_rt | input | 5 | Second source register field of the decoded instruction |
| id_ctl | input | 12 | Decoded control word (bit 4 immediate operand select, bit 1 memory write) |
| ex_dread | input | 1 | Data-read (load) flag of the instruction one stage ahead |
| ex_dst | input | 5 | Destination register of the instruction one stage ahead |
| pc_ld_en | output | 1 | Program counter load enable, 0 during a stall |
| ir_ld_en | output | 1 | Instruction register load enable, 0 during a stall |
| ex_ctl | output | 12 | Control word sent down the pipe, all zeros during a stall |

## Verification
The bench drives load-then-use on each source field, a store whose data register collides, and an immediate-form instruction whose unused second field happens to match. A design that ignored the operand-use rule would insert needless bubbles, and one that ignored stores would let a store write stale data. It drives a load writing register 0, which a naive comparator would stall on. It also holds a colliding load on the inputs for two cycles; a design without the BUBBLE state would stall twice and lose a cycle on every load-use pair. Back-to-back loads are run both dependent and independent, so that both a missed stall and a spurious one are caught.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic {
        ST_FLOW   = 1'b0,
        ST_BUBBLE = 1'b1
    } hz_state_t;

endpackage

// File: rtl/hz_operand_use.sv
module hz_operand_use #(
    parameter int CTRL_W    = 12,
    parameter int IMM_BIT   = 4,
    parameter int STORE_BIT = 1
) (
    input  logic [CTRL_W-1:0] ctl,
    output logic              rs_read,
    output logic              rt_read
);

    // First source is treated as always read: a conservative choice.
    // The second source is read by register-register forms and by stores.
    always_comb begin
        rs_read = 1'b1;
        rt_read = !ctl[IMM_BIT] || ctl[STORE_BIT];
    end

endmodule

// File: rtl/hz_collide.sv
module hz_collide #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] src,
    input  logic [NSRC-1:0]         src_live,
    input  logic                    ahead_dread,
    input  logic [AW-1:0]           ahead_dst,
    output logic                    collide
);

    logic [NSRC-1:0] hit;
    logic            dst_real;

    assign dst_real = (ahead_dst != '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = src_live[i] && (src[i] == ahead_dst);
    end

    assign collide = ahead_dread && dst_real && (|hit);

endmodule

// File: rtl/hz_stall_fsm.sv
module hz_stall_fsm
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic collide,
    output logic stall,
    output hz_state_t state
);

    hz_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                if (collide) begin
                    stall   = 1'b1;
                    state_d = ST_BUBBLE;
                end
            end
            ST_BUBBLE: begin
                state_d = ST_FLOW;
            end
            default: state_d = ST_FLOW;
        endcase
    end

    assign state = state_q;

    p_bubble_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUBBLE) |=> (state_q == ST_FLOW));

endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
    import hz_pkg::*;
#(
    parameter int AW        = 5,
    parameter int CTRL_W    = 12,
    parameter int IMM_BIT   = 4,
    parameter int STORE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     id_rs,
    input  logic [AW-1:0]     id_rt,
    input  logic [CTRL_W-1:0] id_ctl,
    input  logic              ex_dread,
    input  logic [AW-1:0]     ex_dst,
    output logic              pc_ld_en,
    output logic              ir_ld_en,
    output logic [CTRL_W-1:0] ex_ctl
);

    localparam int NSRC = 2;

    logic                    rs_read, rt_read;
    logic [NSRC-1:0][AW-1:0] srcs;
    logic [NSRC-1:0]         live;
    logic                    collide, stall;
    hz_state_t               state;

    hz_operand_use #(.CTRL_W(CTRL_W), .IMM_BIT(IMM_BIT), .STORE_BIT(STORE_BIT)) u_use (
        .ctl     (id_ctl),
        .rs_read (rs_read),
        .rt_read (rt_read)
    );

    assign srcs = {id_rt, id_rs};
    assign live = {rt_read, rs_read};

    hz_collide #(.AW(AW), .NSRC(NSRC)) u_cmp (
        .src         (srcs),
        .src_live    (live),
        .ahead_dread (ex_dread),
        .ahead_dst   (ex_dst),
        .collide     (collide)
    );

    hz_stall_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .collide (collide),
        .stall   (stall),
        .state   (state)
    );

    assign pc_ld_en = !stall;
    assign ir_ld_en = !stall;

    for (genvar b = 0; b < CTRL_W; b++) begin : g_bubble
        assign ex_ctl[b] = id_ctl[b] && !stall;
    end

    p_no_load_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_dread |-> (pc_ld_en && ex_ctl == id_ctl));

    p_rs_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOW && ex_dread && ex_dst != '0 && ex_dst == id_rs)
        |-> (!pc_ld_en && ex_ctl == '0));

    p_rt_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst != id_rs && id_ctl[IMM_BIT] && !id_ctl[STORE_BIT]) |-> pc_ld_en);

    p_zero_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> (pc_ld_en && ex_ctl == id_ctl));

    p_single_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_ld_en |=> pc_ld_en);

    p_enables_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld_en == ir_ld_en);

endmodule

// File: tb/tb_load_use_stall.sv
module tb_load_use_stall;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  id_rs, id_rt, ex_dst;
    logic [11:0] id_ctl;
    logic        ex_dread;
    logic        pc_ld_en, ir_ld_en;
    logic [11:0] ex_ctl;

    int checks = 0;
    int errors = 0;
    bit prev_stall = 1'b0;
    bit done = 1'b0;

    // control words: bit 4 immediate select, bit 1 memory write
    localparam logic [11:0] C_RTYPE = 12'h8A0;
    localparam logic [11:0] C_IMM   = 12'h0D0;
    localparam logic [11:0] C_STORE = 12'h412;
    localparam logic [11:0] C_LOAD  = 12'h234;

    always #10 clk = ~clk;

    load_use_stall dut (
        .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt), .id_ctl(id_ctl),
        .ex_dread(ex_dread), .ex_dst(ex_dst),
        .pc_ld_en(pc_ld_en), .ir_ld_en(ir_ld_en), .ex_ctl(ex_ctl)
    );

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one decode cycle at the falling edge, check before the rising edge.
    task automatic step(input string req, input logic [4:0] rs, input logic [4:0] rt,
                        input logic [11:0] ctl, input logic dr, input logic [4:0] dst);
        bit rt_used, hz, exp_stall;
        @(negedge clk);
        id_rs = rs; id_rt = rt; id_ctl = ctl; ex_dread = dr; ex_dst = dst;
        #2;
        rt_used   = !ctl[4] || ctl[1];
        hz        = dr && dst != 5'd0 && (dst == rs || (rt_used && dst == rt));
        exp_stall = hz && !prev_stall;
        check(req, {pc_ld_en, ir_ld_en, ex_ctl},
              {!exp_stall, !exp_stall, exp_stall ? 12'h000 : ctl});
        prev_stall = exp_stall;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; id_rs = 5'd3; id_rt = 5'd4; id_ctl = C_RTYPE; ex_dread = 1'b0; ex_dst = 5'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R8 reset", {pc_ld_en, ir_ld_en, ex_ctl}, {2'b11, C_RTYPE});
        prev_stall = 1'b0;
    endtask

    task automatic t_no_load();
        step("R1 no load", 5'd7, 5'd7, C_RTYPE, 1'b0, 5'd7);
        step("R1 no load other", 5'd1, 5'd2, C_IMM, 1'b0, 5'd1);
    endtask

    task automatic t_use_rs();
        step("R2 rs stall", 5'd9, 5'd2, C_IMM, 1'b1, 5'd9);
        step("R6 after rs stall", 5'd9, 5'd2, C_IMM, 1'b0, 5'd0);
    endtask

    task automatic t_use_rt();
        step("R3 rt stall", 5'd1, 5'd12, C_RTYPE, 1'b1, 5'd12);
        step("R6 after rt stall", 5'd1, 5'd12, C_RTYPE, 1'b0, 5'd0);
        step("R4 store rt stall", 5'd2, 5'd13, C_STORE, 1'b1, 5'd13);
        step("R6 after store stall", 5'd2, 5'd13, C_STORE, 1'b0, 5'd0);
    endtask

    task automatic t_rt_unused();
        step("R4 imm rt unused", 5'd3, 5'd14, C_IMM, 1'b1, 5'd14);
        step("R4 imm rt unused again", 5'd6, 5'd20, C_IMM, 1'b1, 5'd20);
    endtask

    task automatic t_zero_dst();
        step("R5 dst zero", 5'd0, 5'd0, C_RTYPE, 1'b1, 5'd0);
        step("R5 dst zero store", 5'd0, 5'd0, C_STORE, 1'b1, 5'd0);
    endtask

    task automatic t_held_collision();
        step("R2 held collision first", 5'd17, 5'd0, C_RTYPE, 1'b1, 5'd17);
        step("R6 held collision masked", 5'd17, 5'd0, C_RTYPE, 1'b1, 5'd17);
        step("R2 held collision new pair", 5'd17, 5'd0, C_RTYPE, 1'b1, 5'd17);
    endtask

    task automatic t_back_to_back();
        // previous stall cleared first
        step("R6 clear", 5'd0, 5'd0, C_RTYPE, 1'b0, 5'd0);
        step("R9 load after load independent", 5'd4, 5'd5, C_LOAD, 1'b1, 5'd8);
        step("R2 load after load dependent", 5'd8, 5'd5, C_LOAD, 1'b1, 5'd8);
        step("R6 after dependent load", 5'd8, 5'd5, C_LOAD, 1'b0, 5'd0);
        step("R9 unrelated use", 5'd10, 5'd11, C_RTYPE, 1'b1, 5'd30);
    endtask

    task automatic t_enables();
        for (int i = 1; i < 6; i++) begin
            step("R7 enables sweep", 5'(i), 5'(i + 1), C_RTYPE, 1'b1, 5'(i + 1));
            checks++;
            if (pc_ld_en !== ir_ld_en) begin
                errors++;
                $display("FAIL R7 actual=%b expected=%b", ir_ld_en, pc_ld_en);
            end
        end
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_no_load();
        t_use_rs();
        t_use_rt();
        t_rt_unused();
        t_zero_dst();
        t_held_collision();
        t_back_to_back();
        t_enables();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule